// File: doc/BRIEF.md
# Byte-Stream Configuration Loader

This block sits between a host port that writes one byte at a time and the configuration input of a programmable device. The host pushes a framed image through the write port. A 16-byte header comes first. Its first four bytes carry the payload length as a 32-bit big-endian number, and the remaining twelve bytes are skipped. The loader then forwards exactly that many payload bytes downstream. Each forwarded byte is qualified by a one-cycle valid strobe. After the payload, the loader swallows a fixed trailer of zero padding bytes and reports the outcome through done, busy and error flags plus an error interrupt.

A read from a dedicated reset address restarts the loader. The same read pulses a reset towards the downstream configuration logic, and the read data carries no meaning. The first byte written after such a restart is a throw-away byte; the header starts with the byte after it. If the downstream side reports a fault while the payload is streaming, the load is abandoned. A trailer byte that is not padding also abandons the load. A write after completion is flagged as an error.

Top module: `cfgld_top`

## Requirements
- R1: While rst_n is low and right after it rises, busy, done, error, err_irq, cfg_valid and cfg_reset are all 0.
- R2: A read with host_rd_addr equal to RESET_ADDR (default 0x3C) makes cfg_reset high for exactly the next cycle and clears busy, done, error and err_irq. A read at any other address changes no output and does not disturb a load in progress.
- R3: The first byte written after a restart is discarded. It is not forwarded and busy stays 0.
- R4: Header bytes 0 to 3 form the payload length with byte 0 most significant. Header bytes 4 to 15 have no effect, and no header byte is forwarded.
- R5: Exactly length payload bytes are forwarded in arrival order. Each appears on cfg_data with cfg_valid high for the single cycle after its write.
- R6: After the last payload byte, five 0x00 trailer bytes are consumed and none is forwarded. done rises after the fifth trailer byte and stays high until the next reset read.
- R7: busy is high from the cycle after header byte 0 until the cycle after the last trailer byte. busy is never high together with done.
- R8: With a length of zero, the byte following header byte 15 is treated as the first trailer byte.
- R9: A write while done is high sets error and err_irq, and done stays high.
- R10: cfg_fault high during the payload phase sets error, clears busy, drops the byte written in that cycle and stops all further forwarding. cfg_fault outside the payload phase has no effect.
- R11: A trailer byte other than 0x00 sets error, clears busy, and done does not rise for that image.
- R12: With the default level mode, err_irq is high exactly when error is high.
- R13: A reset read and a byte write in the same cycle act as the reset read alone; the byte is neither forwarded nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rd_addr | input | ADDR_W | Host read address |
| cfg_fault | input | 1 | Fault report from the configuration side |
| cfg_data | output | 8 | Forwarded payload byte |
| cfg_valid | output | 1 | cfg_data qualifier, one cycle per byte |
| cfg_reset | output | 1 | One-cycle reset to the configuration side |
| busy | output | 1 | Image being consumed |
| done | output | 1 | Image completed, sticky |
| error | output | 1 | Load failed or misuse, sticky |
| err_irq | output | 1 | Error interrupt |

## Verification
The hardest case to reach from the ports is a length whose upper bytes are non-zero, because such a length needs a long payload. The stimulus uses a length of 0x00000105, so both low bytes matter and the byte order is exercised within a short run. A fault that coincides with a payload write, and a reset read that coincides with a write, are also hard to reach. They are produced by raising both strobes in the same cycle in the middle of a payload. The outputs in the following cycle then show whether the byte escaped downstream.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   typedef enum logic [2:0] {
      ST_DUMMY = 3'd0,
      ST_HDR   = 3'd1,
      ST_PAY   = 3'd2,
      ST_PAD   = 3'd3,
      ST_DONE  = 3'd4,
      ST_HALT  = 3'd5
   } ld_state_e;
endpackage

// File: rtl/cfgld_hdr.sv
// Header byte counter and big-endian length capture.
module cfgld_hdr #(
   parameter int HDR_BYTES = 16,
   parameter int LEN_BYTES = 4,
   localparam int HC_W  = $clog2(HDR_BYTES),
   localparam int LEN_W = 8 * LEN_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic [7:0]       byte_in,
   output logic             last,
   output logic [LEN_W-1:0] len_q
);
   logic [HC_W-1:0] hcnt_q;
   logic            in_len;

   assign last   = (hcnt_q == HC_W'(HDR_BYTES - 1));
   assign in_len = (int'(hcnt_q) < LEN_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt_q <= '0;
      end else if (clr) begin
         hcnt_q <= '0;
      end else if (take) begin
         hcnt_q <= last ? '0 : hcnt_q + 1'b1;
      end
   end

   generate
      if (LEN_BYTES == 1) begin : g_len1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 len_q <= '0;
            else if (clr)               len_q <= '0;
            else if (take && in_len)    len_q <= byte_in;
         end
      end else begin : g_lenn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 len_q <= '0;
            else if (clr)               len_q <= '0;
            else if (take && in_len)    len_q <= {len_q[LEN_W-9:0], byte_in};
         end
      end
   endgenerate
endmodule

// File: rtl/cfgld_span.sv
// Loadable down counter flagging its final unit.
module cfgld_span #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);
   logic [W-1:0] cnt_q;

   assign last = (cnt_q == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr)        cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (dec)        cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top #(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 'h3C,
   parameter int                HDR_BYTES  = 16,
   parameter int                LEN_BYTES  = 4,
   parameter int                PAD_BYTES  = 5,
   parameter logic [7:0]        PAD_VALUE  = 8'h00,
   parameter bit                IRQ_PULSE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_rd_addr,
   input  logic              cfg_fault,
   output logic [7:0]        cfg_data,
   output logic              cfg_valid,
   output logic              cfg_reset,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic              err_irq
);
   import cfgld_pkg::*;

   localparam int LEN_W = 8 * LEN_BYTES;
   localparam int PAD_W = $clog2(PAD_BYTES + 1);

   generate
      if (LEN_BYTES < 1 || LEN_BYTES > 4)
         $error("cfgld_top: LEN_BYTES must be 1..4");
      if (HDR_BYTES <= LEN_BYTES)
         $error("cfgld_top: header must be longer than the length field");
      if (PAD_BYTES < 1)
         $error("cfgld_top: at least one trailer byte required");
      if (ADDR_W < 1)
         $error("cfgld_top: ADDR_W must be positive");
   endgenerate

   ld_state_e        state_q, state_d;
   logic             rd_rst, wr_acc, fault_hit;
   logic             hdr_take, hdr_last;
   logic [LEN_W-1:0] len_q;
   logic             pay_load, pay_dec, pay_last;
   logic             pad_load, pad_dec, pad_last;
   logic             fwd, set_busy, clr_busy, set_done, set_err;
   logic             busy_q, done_q, err_q, valid_q, rst_pulse_q;
   logic [7:0]       data_q;

   assign rd_rst    = host_rd && (host_rd_addr == RESET_ADDR);
   assign wr_acc    = host_wr && !rd_rst;
   assign fault_hit = cfg_fault && (state_q == ST_PAY) && !rd_rst;

   cfgld_hdr #(.HDR_BYTES(HDR_BYTES), .LEN_BYTES(LEN_BYTES)) u_hdr (
      .clk(clk), .rst_n(rst_n), .clr(rd_rst), .take(hdr_take),
      .byte_in(host_wdata), .last(hdr_last), .len_q(len_q)
   );

   cfgld_span #(.W(LEN_W)) u_pay (
      .clk(clk), .rst_n(rst_n), .clr(rd_rst), .load(pay_load),
      .load_val(len_q), .dec(pay_dec), .last(pay_last)
   );

   cfgld_span #(.W(PAD_W)) u_pad (
      .clk(clk), .rst_n(rst_n), .clr(rd_rst), .load(pad_load),
      .load_val(PAD_W'(PAD_BYTES)), .dec(pad_dec), .last(pad_last)
   );

   always_comb begin
      state_d  = state_q;
      hdr_take = 1'b0;
      pay_load = 1'b0;
      pay_dec  = 1'b0;
      pad_load = 1'b0;
      pad_dec  = 1'b0;
      fwd      = 1'b0;
      set_busy = 1'b0;
      clr_busy = 1'b0;
      set_done = 1'b0;
      set_err  = 1'b0;
      if (fault_hit) begin
         state_d  = ST_HALT;
         set_err  = 1'b1;
         clr_busy = 1'b1;
      end else if (wr_acc) begin
         case (state_q)
            ST_DUMMY: state_d = ST_HDR;
            ST_HDR: begin
               hdr_take = 1'b1;
               set_busy = 1'b1;
               if (hdr_last) begin
                  if (len_q == '0) begin
                     state_d  = ST_PAD;
                     pad_load = 1'b1;
                  end else begin
                     state_d  = ST_PAY;
                     pay_load = 1'b1;
                  end
               end
            end
            ST_PAY: begin
               fwd     = 1'b1;
               pay_dec = 1'b1;
               if (pay_last) begin
                  state_d  = ST_PAD;
                  pad_load = 1'b1;
               end
            end
            ST_PAD: begin
               if (host_wdata != PAD_VALUE) begin
                  state_d  = ST_HALT;
                  set_err  = 1'b1;
                  clr_busy = 1'b1;
               end else begin
                  pad_dec = 1'b1;
                  if (pad_last) begin
                     state_d  = ST_DONE;
                     set_done = 1'b1;
                     clr_busy = 1'b1;
                  end
               end
            end
            ST_DONE: set_err = 1'b1;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_DUMMY;
         busy_q      <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         valid_q     <= 1'b0;
         data_q      <= '0;
         rst_pulse_q <= 1'b0;
      end else if (rd_rst) begin
         state_q     <= ST_DUMMY;
         busy_q      <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         valid_q     <= 1'b0;
         rst_pulse_q <= 1'b1;
      end else begin
         state_q     <= state_d;
         rst_pulse_q <= 1'b0;
         valid_q     <= fwd;
         if (fwd)           data_q <= host_wdata;
         if (clr_busy)      busy_q <= 1'b0;
         else if (set_busy) busy_q <= 1'b1;
         if (set_done)      done_q <= 1'b1;
         if (set_err)       err_q  <= 1'b1;
      end
   end

   generate
      if (IRQ_PULSE) begin : g_irq_pulse
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      irq_q <= 1'b0;
            else if (rd_rst) irq_q <= 1'b0;
            else             irq_q <= set_err && !err_q;
         end
         assign err_irq = irq_q;
      end else begin : g_irq_level
         assign err_irq = err_q;
      end
   endgenerate

   assign cfg_data  = data_q;
   assign cfg_valid = valid_q;
   assign cfg_reset = rst_pulse_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign error     = err_q;
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 'h3C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_rd_addr,
   input logic              cfg_valid,
   input logic              cfg_reset,
   input logic              busy,
   input logic              done,
   input logic              error,
   input logic              err_irq
);
   logic rdr;
   assign rdr = host_rd && (host_rd_addr == RESET_ADDR);

   assert_reset_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rdr |=> (cfg_reset && !busy && !done && !error && !cfg_valid));

   assert_reset_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_reset |-> $past(host_rd));

   assert_valid_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> $past(host_wr));

   assert_valid_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> busy);

   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rdr) |=> done);

   assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !rdr) |=> error);

   assert_irq_on_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> err_irq);
endmodule

bind cfgld_top cfgld_chk #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_rd_addr(host_rd_addr), .cfg_valid(cfg_valid), .cfg_reset(cfg_reset),
   .busy(busy), .done(done), .error(error), .err_irq(err_irq)
);

// File: tb/sim_cfgld_top.sv
module sim_cfgld_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] RST_ADDR = 8'h3C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       host_rd = 1'b0;
   logic [7:0] host_rd_addr = '0;
   logic       cfg_fault = 1'b0;
   logic [7:0] cfg_data;
   logic       cfg_valid, cfg_reset, busy, done, error, err_irq;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgld_top u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rd_addr(host_rd_addr), .cfg_fault(cfg_fault),
      .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cfg_reset(cfg_reset),
      .busy(busy), .done(done), .error(error), .err_irq(err_irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] b, input bit flt);
      @(negedge clk);
      host_wr = 1'b1; host_wdata = b; cfg_fault = flt;
      @(negedge clk);
      host_wr = 1'b0; cfg_fault = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      host_rd = 1'b1; host_rd_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   function automatic logic [7:0] pay_byte(input int len, input int i);
      return 8'((i * 13 + len * 7 + 1) & 8'hFF);
   endfunction

   // Restart, dummy byte and header; poke adds a fault during the header
   task automatic start_image(input int len, input bit poke);
      rd(RST_ADDR);
      check(cfg_reset == 1'b1, "R2 reset pulse", 32'(cfg_reset), 1);
      check(!busy && !done && !error && !err_irq, "R2 flags cleared",
            {busy, done, error, err_irq}, 0);
      wr(8'hFF, 1'b0);
      check(!cfg_reset, "R2 pulse one cycle", 32'(cfg_reset), 0);
      check(!busy && !cfg_valid, "R3 dummy discarded", {busy, cfg_valid}, 0);
      for (int i = 0; i < 16; i++) begin
         logic [7:0] b;
         b = (i < 4) ? 8'(len >> (8 * (3 - i))) : 8'(8'hA5 ^ (i * 17));
         wr(b, poke && (i == 6));
         check(!cfg_valid, "R4 header not forwarded", 32'(cfg_valid), 0);
         check(busy, "R7 busy in header", 32'(busy), 1);
         if (poke && i == 6)
            check(!error, "R10 fault outside payload ignored", 32'(error), 0);
      end
   endtask

   task automatic run_load(input int len, input bit poke);
      start_image(len, poke);
      for (int i = 0; i < len; i++) begin
         wr(pay_byte(len, i), 1'b0);
         check(cfg_valid && cfg_data == pay_byte(len, i), "R5 payload forward",
               {23'd0, cfg_valid, cfg_data}, {23'd1, pay_byte(len, i)});
         if (poke && i == 0) begin
            rd(8'h3D);
            check(!cfg_reset && busy && !cfg_valid, "R2 other address ignored",
                  {cfg_reset, busy, cfg_valid}, 3'b010);
         end
      end
      for (int k = 0; k < 5; k++) begin
         wr(8'h00, 1'b0);
         check(!cfg_valid, "R6 trailer not forwarded", 32'(cfg_valid), 0);
         if (k < 4)
            check(busy && !done, len == 0 ? "R8 zero length trailer" : "R6 trailer pending",
                  {busy, done}, 2'b10);
         else
            check(!busy && done, len == 0 ? "R8 zero length done" : "R6 done after trailer",
                  {busy, done}, 2'b01);
      end
      check(!error && !err_irq, "R12 no error on clean load", {error, err_irq}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !error && !err_irq && !cfg_valid && !cfg_reset,
            "R1 in reset", {busy, done, error, err_irq, cfg_valid, cfg_reset}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !error && !err_irq && !cfg_valid && !cfg_reset,
            "R1 after reset", {busy, done, error, err_irq, cfg_valid, cfg_reset}, 0);

      // Length sweep, with R4 byte order via 0x105
      for (int len = 0; len <= 8; len++) run_load(len, len == 3);
      run_load(261, 1'b0);

      // R9: write after done
      wr(8'h00, 1'b0);
      check(error && err_irq && done, "R9 write after done",
            {error, err_irq, done}, 3'b111);
      check(err_irq == error, "R12 irq level", 32'(err_irq), 32'(error));
      wr(8'h00, 1'b0);
      check(done && error, "R6 done sticky", {done, error}, 2'b11);

      // R10: fault together with a payload write
      start_image(10, 1'b0);
      for (int i = 0; i < 3; i++) wr(pay_byte(10, i), 1'b0);
      wr(8'h77, 1'b1);
      check(!cfg_valid && error && !busy && err_irq, "R10 fault stops load",
            {cfg_valid, error, busy, err_irq}, 4'b0101);
      for (int i = 0; i < 12; i++) begin
         wr(8'h00, 1'b0);
         check(!cfg_valid && !done, "R10 no forwarding after fault",
               {cfg_valid, done}, 0);
      end

      // R11: bad trailer byte
      start_image(2, 1'b0);
      wr(8'h10, 1'b0); wr(8'h20, 1'b0);
      wr(8'h00, 1'b0); wr(8'h00, 1'b0);
      wr(8'h01, 1'b0);
      check(error && !busy && !done && err_irq, "R11 bad pad byte",
            {error, busy, done, err_irq}, 4'b1001);
      for (int i = 0; i < 4; i++) wr(8'h00, 1'b0);
      check(!done && !cfg_valid, "R11 no done after bad pad", {done, cfg_valid}, 0);

      // R13: reset read collides with a payload write
      start_image(6, 1'b0);
      wr(8'h31, 1'b0); wr(8'h32, 1'b0);
      @(negedge clk);
      host_wr = 1'b1; host_wdata = 8'hAA; host_rd = 1'b1; host_rd_addr = RST_ADDR;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      check(!cfg_valid && cfg_reset && !busy, "R13 reset wins",
            {cfg_valid, cfg_reset, busy}, 3'b010);
      wr(8'h55, 1'b0);
      check(!busy && !cfg_valid, "R13 next write is dummy", {busy, cfg_valid}, 0);
      wr(8'h00, 1'b0);
      check(busy && !cfg_valid, "R13 header follows", {busy, cfg_valid}, 2'b10);

      run_load(1, 1'b0);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule